// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a packet DMA engine. Incoming frames arrive from the MAC as a byte stream with start, end and error markers. The engine places each frame into a host buffer named by the descriptor at the current ring position, then updates that descriptor: it clears the hardware-ownership flag, records the received byte count (with the trailing 4-byte CRC still counted) and records an error flag. It then raises a receive-done interrupt cause and moves on to the next ring slot, wrapping at the end of the ring.

Software owns the descriptors and gives each one back to hardware by setting its ownership flag. It also grants a budget of usable slots through a kick register, turns reception on and off through a control bit, and masks interrupt causes. The descriptor table lives inside the block as a small array that the register port reads and writes. Buffer bytes leave the block on a one-byte-per-cycle write port. The engine never stalls the MAC: a frame that finds no usable slot is discarded and counted.

Top module: `rxring_engine`

## Requirements
- R1: After reset the engine is disabled, the ring index, slot budget, missed-frame count and status register read 0, the mask register reads all ones and `irq` is 0.
- R2: A frame that starts while the engine is enabled, the budget is non-zero and the current descriptor has bit 31 (ownership) of its command word set, is written byte by byte in arrival order to consecutive addresses starting at the descriptor's buffer address, one `dma_we` pulse per byte.
- R3: At the frame's last byte the current descriptor's command word is rewritten with bit 31 cleared, bits 30:16 holding the number of bytes received (CRC included) and bits 15:0 unchanged; the status word gets bit 30 clear for a clean frame.
- R4: A frame longer than the buffer (2048 bytes by default) writes only the first 2048 bytes, reports a length of 2048 and sets bit 30 of the status word.
- R5: A frame whose error marker is raised on any byte still completes its descriptor, with its length recorded and bit 30 of the status word set.
- R6: Each completed frame moves the ring index up by one, from 31 back to 0; a one-byte frame (start and end on the same byte) is a complete frame.
- R7: A frame that starts while the engine is enabled but the current descriptor is not owned by hardware or the budget is zero writes no bytes, leaves the descriptor and ring index untouched, adds one to the missed-frame count and sets status bit 1.
- R8: A kick write loads the budget with the written value, limited to the ring size; each completed frame uses up one unit of budget.
- R9: Status bit 0 is set by each completed frame; `irq` is 1 exactly when some status bit is 1 whose mask bit is 0.
- R10: Reading the status register returns its value and clears it; a cause arriving in the same cycle as the read stays set.
- R11: With control bit 0 clear, incoming frames are ignored entirely (no write, no count); clearing it in the middle of a frame abandons that frame and leaves its descriptor owned by hardware.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status when it selects it) |
| reg_addr | input | REG_AW (8) | Register address; top bit selects the descriptor table, then slot index, then word (0 buffer address, 1 command, 2 status); otherwise low 3 bits: 0 control, 1 kick, 2 mask, 3 status, 4 missed count, 5 ring index, 6 budget |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| rx_valid | input | 1 | A frame byte is present |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | MAC reports an error in the frame |
| rx_data | input | 8 | Frame byte |
| dma_we | output | 1 | Buffer byte write strobe |
| dma_addr | output | ADDR_W (32) | Buffer byte address |
| dma_byte | output | 8 | Buffer byte |
| irq | output | 1 | Interrupt request |

## Verification
On every cycle the assertions check that the ring index only ever steps by one slot with wrap, that the budget never exceeds the ring size, that the missed count never jumps by more than one, that a descriptor is only written back while hardware owns it, and that a status read with no new cause leaves the status at zero. The scenarios are needed for the byte addresses and order, the exact length and error values written back, truncation at the buffer edge, the drop paths for an unowned slot, an empty budget and a disabled engine, the mid-frame abort, and the masking that decides `irq`.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
   typedef enum logic [1:0] {
      RX_IDLE,
      RX_RECV,
      RX_DROP
   } rx_state_e;

   localparam int OWN_BIT = 31;
   localparam int ERR_BIT = 30;
   localparam int LEN_LSB = 16;
   localparam int LEN_W   = OWN_BIT - LEN_LSB;

   localparam logic [1:0] DW_ADDR = 2'd0;
   localparam logic [1:0] DW_CMD  = 2'd1;
   localparam logic [1:0] DW_STAT = 2'd2;

   localparam logic [2:0] RG_CTRL   = 3'd0;
   localparam logic [2:0] RG_KICK   = 3'd1;
   localparam logic [2:0] RG_MASK   = 3'd2;
   localparam logic [2:0] RG_STATUS = 3'd3;
   localparam logic [2:0] RG_MISSED = 3'd4;
   localparam logic [2:0] RG_INDEX  = 3'd5;
   localparam logic [2:0] RG_BUDGET = 3'd6;
endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
   import rxr_pkg::*;
#(
   parameter int NUM_DESC = 32,
   parameter int ADDR_W   = 32,
   parameter int IDX_W    = $clog2(NUM_DESC)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [1:0]        host_word,
   input  logic [31:0]       host_wdata,
   output logic [31:0]       host_rdata,
   input  logic              hw_wb,
   input  logic [IDX_W-1:0]  hw_idx,
   input  logic [31:0]       hw_cmd,
   input  logic [31:0]       hw_stat,
   output logic [ADDR_W-1:0] slot_addr,
   output logic [31:0]       slot_cmd
);
   logic [ADDR_W-1:0] addr_q [NUM_DESC];
   logic [31:0]       cmd_q  [NUM_DESC];
   logic [31:0]       stat_q [NUM_DESC];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_DESC; i++) begin
            addr_q[i] <= '0;
            cmd_q[i]  <= '0;
            stat_q[i] <= '0;
         end
      end else begin
         for (int i = 0; i < NUM_DESC; i++) begin
            if (hw_wb && hw_idx == IDX_W'(i)) begin
               cmd_q[i]  <= hw_cmd;
               stat_q[i] <= hw_stat;
            end else if (host_we && host_idx == IDX_W'(i)) begin
               if (host_word == DW_CMD)  cmd_q[i]  <= host_wdata;
               if (host_word == DW_STAT) stat_q[i] <= host_wdata;
            end
            if (host_we && host_idx == IDX_W'(i) && host_word == DW_ADDR)
               addr_q[i] <= host_wdata[ADDR_W-1:0];
         end
      end
   end

   always_comb begin
      unique case (host_word)
         DW_ADDR: host_rdata = 32'(addr_q[host_idx]);
         DW_CMD:  host_rdata = cmd_q[host_idx];
         DW_STAT: host_rdata = stat_q[host_idx];
         default: host_rdata = '0;
      endcase
   end

   assign slot_addr = addr_q[hw_idx];
   assign slot_cmd  = cmd_q[hw_idx];

   // R3: a descriptor is only completed while hardware owns it
   assert_wb_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hw_wb |-> cmd_q[hw_idx][OWN_BIT]);
endmodule

// File: rtl/rxr_irq.sv
module rxr_irq #(
   parameter int CAUSE_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CAUSE_W-1:0] cause_set,
   input  logic               rd_clear,
   input  logic               mask_we,
   input  logic [CAUSE_W-1:0] mask_wdata,
   output logic [CAUSE_W-1:0] status,
   output logic [CAUSE_W-1:0] mask,
   output logic               irq
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         status <= (rd_clear ? '0 : status) | cause_set;
         if (mask_we) mask <= mask_wdata;
      end
   end

   assign irq = |(status & ~mask);

   // R10: a read with no new cause leaves nothing behind
   assert_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && cause_set == '0) |=> status == '0);
endmodule

// File: rtl/rxr_rx_fsm.sv
module rxr_rx_fsm
   import rxr_pkg::*;
#(
   parameter int NUM_DESC   = 32,
   parameter int BUF_BYTES  = 2048,
   parameter int ADDR_W     = 32,
   parameter int MISS_W     = 16,
   parameter bit MISSED_SAT = 1'b1,
   parameter int IDX_W      = $clog2(NUM_DESC),
   parameter int OFS_W      = $clog2(BUF_BYTES + 1),
   parameter int CRED_W     = $clog2(NUM_DESC + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic [7:0]        rx_data,
   input  logic [ADDR_W-1:0] slot_addr,
   input  logic [31:0]       slot_cmd,
   input  logic              kick_we,
   input  logic [31:0]       kick_val,
   output logic [IDX_W-1:0]  cur_idx,
   output logic [CRED_W-1:0] budget,
   output logic              dma_we,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [7:0]        dma_byte,
   output logic              wb_en,
   output logic [31:0]       wb_cmd,
   output logic [31:0]       wb_stat,
   output logic              done_evt,
   output logic              miss_evt,
   output logic [MISS_W-1:0] missed
);
   localparam logic [OFS_W-1:0]  OFS_MAX  = OFS_W'(BUF_BYTES);
   localparam logic [IDX_W-1:0]  IDX_LAST = IDX_W'(NUM_DESC - 1);
   localparam logic [CRED_W-1:0] CRED_MAX = CRED_W'(NUM_DESC);

   rx_state_e         state;
   logic [OFS_W-1:0]  cnt;
   logic              bad_q;
   logic [ADDR_W-1:0] base_q;

   logic start, can_take, accept, body, room, take_byte, fin, err_fin;
   logic [LEN_W-1:0] len_fin;

   always_comb begin
      start     = rx_valid && rx_sof;
      can_take  = en && (budget != '0) && slot_cmd[OWN_BIT];
      accept    = start && can_take;
      body      = rx_valid && !rx_sof && (state == RX_RECV) && en;
      room      = cnt < OFS_MAX;
      take_byte = accept || (body && room);
      fin       = rx_valid && rx_eof && (accept || body);
      if (accept)    len_fin = LEN_W'(1);
      else if (room) len_fin = LEN_W'(cnt) + LEN_W'(1);
      else           len_fin = LEN_W'(cnt);
      err_fin   = accept ? rx_err : (bad_q || rx_err || !room);
      wb_en     = fin;
      wb_cmd    = {1'b0, len_fin, slot_cmd[LEN_LSB-1:0]};
      wb_stat   = 32'(err_fin) << ERR_BIT;
      done_evt  = fin;
      miss_evt  = start && en && !can_take;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= RX_IDLE;
         cnt      <= '0;
         bad_q    <= 1'b0;
         base_q   <= '0;
         dma_we   <= 1'b0;
         dma_addr <= '0;
         dma_byte <= '0;
         cur_idx  <= '0;
         budget   <= '0;
      end else begin
         dma_we <= take_byte;
         if (take_byte) begin
            dma_addr <= accept ? slot_addr : base_q + ADDR_W'(cnt);
            dma_byte <= rx_data;
         end

         if (start) begin
            cnt    <= OFS_W'(1);
            bad_q  <= rx_err;
            base_q <= slot_addr;
            if (rx_eof)      state <= RX_IDLE;
            else if (accept) state <= RX_RECV;
            else             state <= RX_DROP;
         end else if (state == RX_RECV && !en) begin
            state <= RX_DROP;
         end else if (rx_valid && state == RX_RECV) begin
            if (room) cnt <= cnt + OFS_W'(1);
            bad_q <= bad_q || rx_err || !room;
            if (rx_eof) state <= RX_IDLE;
         end else if (rx_valid && state == RX_DROP && rx_eof) begin
            state <= RX_IDLE;
         end

         if (fin) cur_idx <= (cur_idx == IDX_LAST) ? '0 : cur_idx + IDX_W'(1);

         if (kick_we)
            budget <= (kick_val > 32'(NUM_DESC)) ? CRED_MAX : kick_val[CRED_W-1:0];
         else if (fin)
            budget <= budget - CRED_W'(1);
      end
   end

   generate
      if (MISSED_SAT) begin : g_miss_sat
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) missed <= '0;
            else if (miss_evt && missed != '1) missed <= missed + MISS_W'(1);
         end
      end else begin : g_miss_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) missed <= '0;
            else if (miss_evt) missed <= missed + MISS_W'(1);
         end
      end
   endgenerate

   // R6: ring index moves by exactly one slot, wrapping at the end
   assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx != $past(cur_idx)) |->
         (cur_idx == (($past(cur_idx) == IDX_LAST) ? '0 : $past(cur_idx) + IDX_W'(1))));

   // R8: budget never exceeds the ring size
   assert_budget_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      budget <= CRED_MAX);

   // R7: missed count grows by at most one per cycle
   assert_miss_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (missed == $past(missed)) || (missed == $past(missed) + MISS_W'(1)));
endmodule

// File: rtl/rxring_engine.sv
module rxring_engine
   import rxr_pkg::*;
#(
   parameter int NUM_DESC   = 32,
   parameter int BUF_BYTES  = 2048,
   parameter int ADDR_W     = 32,
   parameter int MISS_W     = 16,
   parameter bit MISSED_SAT = 1'b1,
   parameter int CAUSE_W    = 8,
   parameter int RXDONE_BIT = 0,
   parameter int MISS_BIT   = 1,
   parameter int REG_AW     = $clog2(NUM_DESC) + 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              rx_valid,
   input  logic              rx_sof,
   input  logic              rx_eof,
   input  logic              rx_err,
   input  logic [7:0]        rx_data,
   output logic              dma_we,
   output logic [ADDR_W-1:0] dma_addr,
   output logic [7:0]        dma_byte,
   output logic              irq
);
   localparam int IDX_W  = $clog2(NUM_DESC);
   localparam int OFS_W  = $clog2(BUF_BYTES + 1);
   localparam int CRED_W = $clog2(NUM_DESC + 1);

   generate
      if (NUM_DESC < 2 || BUF_BYTES >= (1 << LEN_W) || BUF_BYTES < 1)
         $error("rxring_engine: ring or buffer size out of range");
      if (ADDR_W > 32 || MISS_W > 32 || CAUSE_W > 32 || CAUSE_W < 2)
         $error("rxring_engine: field width out of range");
      if (RXDONE_BIT >= CAUSE_W || MISS_BIT >= CAUSE_W || RXDONE_BIT == MISS_BIT)
         $error("rxring_engine: cause bit placement invalid");
      if (REG_AW != IDX_W + 3)
         $error("rxring_engine: register address width must be index width plus 3");
   endgenerate

   logic              in_table;
   logic [IDX_W-1:0]  tbl_idx;
   logic [1:0]        tbl_word;
   logic [2:0]        rsel;
   logic              ctrl_en;
   logic              kick_we, mask_we, stat_rd;
   logic [31:0]       tbl_rdata;
   logic [ADDR_W-1:0] slot_addr;
   logic [31:0]       slot_cmd;
   logic [IDX_W-1:0]  cur_idx;
   logic [CRED_W-1:0] budget;
   logic              wb_en, done_evt, miss_evt;
   logic [31:0]       wb_cmd, wb_stat;
   logic [MISS_W-1:0] missed;
   logic [CAUSE_W-1:0] cause_set, status, mask;

   assign in_table = reg_addr[REG_AW-1];
   assign tbl_idx  = reg_addr[IDX_W+1:2];
   assign tbl_word = reg_addr[1:0];
   assign rsel     = reg_addr[2:0];
   assign kick_we  = reg_wr && !in_table && rsel == RG_KICK;
   assign mask_we  = reg_wr && !in_table && rsel == RG_MASK;
   assign stat_rd  = reg_rd && !in_table && rsel == RG_STATUS;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_en <= 1'b0;
      else if (reg_wr && !in_table && rsel == RG_CTRL) ctrl_en <= reg_wdata[0];
   end

   rxr_desc_mem #(
      .NUM_DESC(NUM_DESC), .ADDR_W(ADDR_W), .IDX_W(IDX_W)
   ) u_mem (
      .clk(clk), .rst_n(rst_n),
      .host_we(reg_wr && in_table), .host_idx(tbl_idx), .host_word(tbl_word),
      .host_wdata(reg_wdata), .host_rdata(tbl_rdata),
      .hw_wb(wb_en), .hw_idx(cur_idx), .hw_cmd(wb_cmd), .hw_stat(wb_stat),
      .slot_addr(slot_addr), .slot_cmd(slot_cmd)
   );

   rxr_rx_fsm #(
      .NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .ADDR_W(ADDR_W),
      .MISS_W(MISS_W), .MISSED_SAT(MISSED_SAT),
      .IDX_W(IDX_W), .OFS_W(OFS_W), .CRED_W(CRED_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .en(ctrl_en),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof),
      .rx_err(rx_err), .rx_data(rx_data),
      .slot_addr(slot_addr), .slot_cmd(slot_cmd),
      .kick_we(kick_we), .kick_val(reg_wdata),
      .cur_idx(cur_idx), .budget(budget),
      .dma_we(dma_we), .dma_addr(dma_addr), .dma_byte(dma_byte),
      .wb_en(wb_en), .wb_cmd(wb_cmd), .wb_stat(wb_stat),
      .done_evt(done_evt), .miss_evt(miss_evt), .missed(missed)
   );

   always_comb begin
      cause_set = '0;
      cause_set[RXDONE_BIT] = done_evt;
      cause_set[MISS_BIT]   = miss_evt;
   end

   rxr_irq #(.CAUSE_W(CAUSE_W)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .cause_set(cause_set), .rd_clear(stat_rd),
      .mask_we(mask_we), .mask_wdata(reg_wdata[CAUSE_W-1:0]),
      .status(status), .mask(mask), .irq(irq)
   );

   always_comb begin
      if (in_table) begin
         reg_rdata = tbl_rdata;
      end else begin
         unique case (rsel)
            RG_CTRL:   reg_rdata = 32'(ctrl_en);
            RG_MASK:   reg_rdata = 32'(mask);
            RG_STATUS: reg_rdata = 32'(status);
            RG_MISSED: reg_rdata = 32'(missed);
            RG_INDEX:  reg_rdata = 32'(cur_idx);
            RG_BUDGET: reg_rdata = 32'(budget);
            default:   reg_rdata = '0;
         endcase
      end
   end
endmodule

// File: tb/sim_rxring_engine.sv
module sim_rxring_engine;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] BUF0 = 32'h1000_0000;
   localparam logic [31:0] OWN  = 32'h8000_0000;

   logic clk = 0;
   logic rst_n = 0;
   logic reg_wr = 0, reg_rd = 0;
   logic [7:0] reg_addr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
   logic [7:0] rx_data = 0;
   logic dma_we;
   logic [31:0] dma_addr;
   logic [7:0] dma_byte;
   logic irq;

   int total = 0, bad = 0;
   int wr_count = 0, seq_bad = 0;
   logic [31:0] exp_base = 0;
   logic [7:0]  exp_first = 0;
   logic [31:0] v;

   always #(CLK_PERIOD/2) clk = ~clk;

   rxring_engine u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
      .rx_data(rx_data), .dma_we(dma_we), .dma_addr(dma_addr),
      .dma_byte(dma_byte), .irq(irq)
   );

   always @(negedge clk) begin
      if (dma_we) begin
         if (dma_addr !== exp_base + 32'(wr_count) || dma_byte !== exp_first + 8'(wr_count))
            seq_bad++;
         wr_count++;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic reg_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_wr = 0;
   endtask

   task automatic reg_read(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
      @(negedge clk); reg_rd = 0;
   endtask

   function automatic logic [7:0] da(input int idx, input int w);
      return {1'b1, 5'(idx), 2'(w)};
   endfunction

   function automatic logic [31:0] tag(input int idx);
      return 32'h0000_C000 + 32'(idx);
   endfunction

   task automatic send_frame(input int len, input logic [7:0] first, input bit err_last, input int abort_at);
      wr_count = 0; seq_bad = 0; exp_first = first;
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         rx_valid = 1; rx_sof = (k == 0); rx_eof = (k == len - 1);
         rx_err = err_last && (k == len - 1); rx_data = first + 8'(k);
         if (k == abort_at) begin reg_wr = 1; reg_addr = 8'd0; reg_wdata = 0; end
         else reg_wr = 0;
      end
      @(negedge clk);
      rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; reg_wr = 0;
      #1;
   endtask

   task automatic arm_all();
      for (int i = 0; i < 32; i++) begin
         reg_write(da(i, 0), BUF0 + 32'(i) * 32'd2048);
         reg_write(da(i, 1), OWN | tag(i));
         reg_write(da(i, 2), 32'h0);
      end
   endtask

   task automatic t_reset();
      reg_read(8'd0, v); chk(v == 0, "R1 ctrl", v, 0);
      reg_read(8'd5, v); chk(v == 0, "R1 index", v, 0);
      reg_read(8'd6, v); chk(v == 0, "R1 budget", v, 0);
      reg_read(8'd4, v); chk(v == 0, "R1 missed", v, 0);
      reg_read(8'd2, v); chk(v == 32'hFF, "R1 mask", v, 32'hFF);
      reg_read(8'd3, v); chk(v == 0, "R1 status", v, 0);
      chk(irq == 0, "R1 irq", 32'(irq), 0);
   endtask

   task automatic t_basic();
      exp_base = BUF0;
      send_frame(64, 8'h10, 0, -1);
      chk(wr_count == 64, "R2 byte count", wr_count, 64);
      chk(seq_bad == 0, "R2 address/order", seq_bad, 0);
      reg_read(da(0, 1), v); chk(v == {1'b0, 15'd64, 16'hC000}, "R3 cmd word", v, {1'b0, 15'd64, 16'hC000});
      reg_read(da(0, 2), v); chk(v[30] == 0, "R3 status clean", v, 0);
      reg_read(8'd5, v); chk(v == 1, "R6 index step", v, 1);
      reg_read(8'd6, v); chk(v == 31, "R8 budget used", v, 31);
   endtask

   task automatic t_irq();
      chk(irq == 0, "R9 masked irq", 32'(irq), 0);
      reg_read(8'd3, v); chk(v == 1, "R9 rxdone cause", v, 1);
      reg_read(8'd3, v); chk(v == 0, "R10 read clears", v, 0);
      reg_write(8'd2, 32'hFE);
      exp_base = BUF0 + 32'd2048;
      send_frame(8, 8'h40, 0, -1);
      chk(irq == 1, "R9 unmasked irq", 32'(irq), 1);
      reg_read(8'd3, v); chk(v == 1, "R10 status value", v, 1);
      #1 chk(irq == 0, "R10 irq after read", 32'(irq), 0);
   endtask

   task automatic t_trunc();
      exp_base = BUF0 + 32'd2 * 32'd2048;
      send_frame(2050, 8'h00, 0, -1);
      chk(wr_count == 2048, "R4 bytes kept", wr_count, 2048);
      chk(seq_bad == 0, "R4 address/order", seq_bad, 0);
      reg_read(da(2, 1), v); chk(v == {1'b0, 15'd2048, 16'hC002}, "R4 length", v, {1'b0, 15'd2048, 16'hC002});
      reg_read(da(2, 2), v); chk(v == 32'h4000_0000, "R4 error flag", v, 32'h4000_0000);
   endtask

   task automatic t_err();
      exp_base = BUF0 + 32'd3 * 32'd2048;
      send_frame(10, 8'h80, 1, -1);
      reg_read(da(3, 1), v); chk(v == {1'b0, 15'd10, 16'hC003}, "R5 length", v, {1'b0, 15'd10, 16'hC003});
      reg_read(da(3, 2), v); chk(v == 32'h4000_0000, "R5 error flag", v, 32'h4000_0000);
      reg_read(8'd3, v);
   endtask

   task automatic t_notown();
      reg_write(da(4, 1), tag(4));
      send_frame(12, 8'h20, 0, -1);
      chk(wr_count == 0, "R7 no writes", wr_count, 0);
      reg_read(8'd4, v); chk(v == 1, "R7 missed count", v, 1);
      reg_read(8'd5, v); chk(v == 4, "R7 index held", v, 4);
      reg_read(da(4, 1), v); chk(v == tag(4), "R7 descriptor untouched", v, tag(4));
      reg_read(8'd3, v); chk(v == 2, "R7 missed cause", v, 2);
      reg_write(da(4, 1), OWN | tag(4));
   endtask

   task automatic t_disable();
      reg_write(8'd0, 0);
      send_frame(6, 8'h30, 0, -1);
      chk(wr_count == 0, "R11 disabled no writes", wr_count, 0);
      reg_read(8'd4, v); chk(v == 1, "R11 disabled not counted", v, 1);
      reg_read(8'd5, v); chk(v == 4, "R11 disabled index", v, 4);
      reg_write(8'd0, 1);
      exp_base = BUF0 + 32'd4 * 32'd2048;
      send_frame(20, 8'h50, 0, 5);
      reg_read(da(4, 1), v); chk(v == (OWN | tag(4)), "R11 abort keeps ownership", v, OWN | tag(4));
      reg_read(8'd5, v); chk(v == 4, "R11 abort index", v, 4);
      reg_write(8'd0, 1);
   endtask

   task automatic t_budget();
      reg_read(8'd6, v); chk(v == 28, "R8 budget", v, 28);
      reg_write(8'd1, 0);
      send_frame(5, 8'h60, 0, -1);
      chk(wr_count == 0, "R8 empty budget drops", wr_count, 0);
      reg_read(8'd4, v); chk(v == 2, "R8 empty budget counted", v, 2);
      reg_write(8'd1, 40);
      reg_read(8'd6, v); chk(v == 32, "R8 kick limit", v, 32);
   endtask

   task automatic t_wrap();
      arm_all();
      for (int i = 4; i < 32; i++) begin
         exp_base = BUF0 + 32'(i) * 32'd2048;
         send_frame(1, 8'(i), 0, -1);
      end
      reg_read(8'd5, v); chk(v == 0, "R6 wrap to 0", v, 0);
      reg_read(da(31, 1), v); chk(v == {1'b0, 15'd1, 16'hC01F}, "R6 one-byte frame", v, {1'b0, 15'd1, 16'hC01F});
      exp_base = BUF0;
      send_frame(3, 8'h70, 0, -1);
      chk(wr_count == 3 && seq_bad == 0, "R6 slot 0 reused", wr_count, 3);
      reg_read(8'd5, v); chk(v == 1, "R6 index after wrap", v, 1);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      arm_all();
      reg_write(8'd1, 32);
      reg_write(8'd0, 1);
      t_basic();
      t_irq();
      t_trunc();
      t_err();
      t_notown();
      t_disable();
      t_budget();
      t_wrap();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule